// File: doc/BRIEF.md
# Block Memory Mover

This controller moves a block of words from a device into main memory without the processor doing the copying. Software loads a destination address and a word count through a small register write port, then writes a start command. The controller answers the start with a one-cycle setup acknowledge before any data moves. It then repeats one loop for each word. It requests the shared memory bus, waits for the grant, and writes one word at the current address. When memory signals that the write is accepted, it releases the bus.

Device words arrive on a ready/valid stream and go into a local first-in first-out buffer. The device can burst without regard to bus timing. When the last word has been written, the controller returns to idle and sets a sticky completion interrupt. Software clears that flag by writing to the status register.

The state machine has six states:
- IDLE: waits for a start.
- ACK: the setup acknowledge cycle.
- WAIT: no bus request; waits until the buffer holds a word.
- REQ: bus request raised; waits for the grant.
- WRITE: drives the word until memory accepts it.
- FINISH: the last cycle marked busy.

Transitions:
- IDLE to ACK on a start.
- ACK to FINISH when the count is zero, otherwise ACK to WAIT.
- WAIT to REQ when the buffer is non-empty.
- REQ to WRITE on grant.
- WRITE to WAIT on an accepted word that is not the last.
- WRITE to FINISH on an accepted last word.
- FINISH to IDLE always.

Top module: `dma_word_mover`

## Requirements
- R1: A write with `cfg_sel`=0 loads the destination address and `cfg_sel`=1 loads the word count. Both are taken from `cfg_wdata`, and both writes are ignored while `busy` is high.
- R2: A write with `cfg_sel`=2 while idle starts a transfer. On the next cycle `busy` is high and `setup_ack` is high for exactly that one cycle, with `bus_req` low.
- R3: The device buffer holds 16 words. `dev_ready` is low exactly when 16 words are held, and a word is taken when `dev_valid` and `dev_ready` are both high.
- R4: `bus_req` is high only in the request and write states. It is raised only when the buffer holds a word, and it is low in the cycle after each accepted write.
- R5: `mem_we`, `mem_addr` and `mem_wdata` are driven only in the write state, after `bus_gnt` has been seen. When `mem_we` is low they are zero.
- R6: A write is accepted on a cycle where `mem_we` and `mem_wready` are both high. The first word goes to the programmed address, and each later word goes to the previous address plus one. Words leave in the order the device supplied them.
- R7: After exactly the programmed number of accepted writes, `busy` falls and `irq` rises. When not busy, `bus_req` and `mem_we` stay low.
- R8: A start with a count of zero raises `setup_ack` and then `irq` without ever raising `bus_req`.
- R9: A start written while `busy` is high is ignored, and the running transfer continues unchanged.
- R10: `irq` stays high until a write with `cfg_sel`=3. That write clears it unless completion sets it in the same cycle.
- R11: After reset `busy`, `irq`, `setup_ack`, `bus_req` and `mem_we` are low and `dev_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 start, 3 clear interrupt |
| cfg_wdata | input | AW | Register write data |
| busy | output | 1 | Transfer in progress |
| setup_ack | output | 1 | One-cycle acknowledge of a start |
| irq | output | 1 | Sticky completion interrupt |
| dev_valid | input | 1 | Device word valid |
| dev_data | input | DW | Device word |
| dev_ready | output | 1 | Buffer can take a word |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_wready | input | 1 | Memory accepts the write |

## Verification
The assertions assume that the arbiter keeps `bus_gnt` high for as long as `bus_req` stays high once it has granted, and drops it when the request falls. They also assume that `mem_wready` is only meaningful while `mem_we` is high. The bench's arbiter grants on a fixed cycle pattern and then holds the grant until the request falls, so it stays inside those assumptions. Memory acceptance is stretched on alternate cycles. The device stream, the register writes and the resulting bus traffic are all mirrored by a queue-based model.

// File: rtl/dma_mover_pkg.sv
package dma_mover_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK,
        ST_WAIT,
        ST_REQ,
        ST_WRITE,
        ST_FINISH
    } mover_state_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_START = 2'd2;
    localparam logic [1:0] SEL_CLEAR = 2'd3;
endpackage

// File: rtl/dma_word_fifo.sv
module dma_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] LVL_FULL = LW'(DEPTH);

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LVL_FULL);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      level <= level + LW'(1);
            else if (do_pop && !do_push) level <= level - LW'(1);
        end
    end
endmodule

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
    import dma_mover_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          busy,
    input  logic          done,
    output logic [AW-1:0] base_addr,
    output logic [AW-1:0] word_count,
    output logic          start,
    output logic          irq
);
    assign start = cfg_wr && (cfg_sel == SEL_START) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr  <= '0;
            word_count <= '0;
            irq        <= 1'b0;
        end else begin
            if (cfg_wr && !busy && cfg_sel == SEL_ADDR)  base_addr  <= cfg_wdata;
            if (cfg_wr && !busy && cfg_sel == SEL_COUNT) word_count <= cfg_wdata;
            if (done)                                   irq <= 1'b1;
            else if (cfg_wr && cfg_sel == SEL_CLEAR)    irq <= 1'b0;
        end
    end
endmodule

// File: rtl/dma_move_fsm.sv
module dma_move_fsm
    import dma_mover_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] word_count,
    input  logic          buf_empty,
    input  logic [DW-1:0] buf_head,
    input  logic          bus_gnt,
    input  logic          mem_wready,
    output logic          busy,
    output logic          setup_ack,
    output logic          bus_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          buf_pop,
    output logic          done
);
    mover_state_t state, state_nx;
    logic [AW-1:0] cur_addr;
    logic [AW-1:0] left;
    logic          accepted;

    assign accepted = (state == ST_WRITE) && mem_wready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            left     <= '0;
        end else begin
            state <= state_nx;
            if (start) begin
                cur_addr <= base_addr;
                left     <= word_count;
            end else if (accepted) begin
                cur_addr <= cur_addr + AW'(1);
                left     <= left - AW'(1);
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_ACK;
            ST_ACK:    state_nx = (left == '0) ? ST_FINISH : ST_WAIT;
            ST_WAIT:   if (!buf_empty) state_nx = ST_REQ;
            ST_REQ:    if (bus_gnt) state_nx = ST_WRITE;
            ST_WRITE:  if (mem_wready) state_nx = (left == AW'(1)) ? ST_FINISH : ST_WAIT;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        setup_ack = (state == ST_ACK);
        bus_req   = (state == ST_REQ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = mem_we ? cur_addr : '0;
        mem_wdata = mem_we ? buf_head : '0;
        buf_pop   = accepted;
        done      = (state == ST_FINISH);
    end
endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          busy,
    output logic          setup_ack,
    output logic          irq,
    input  logic          dev_valid,
    input  logic [DW-1:0] dev_data,
    output logic          dev_ready,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_wready
);
    logic [AW-1:0] base_addr, word_count;
    logic          start, done, buf_pop, buf_empty, buf_full;
    logic [DW-1:0] buf_head;

    assign dev_ready = !buf_full;

    dma_cfg_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .done(done),
        .base_addr(base_addr), .word_count(word_count), .start(start), .irq(irq)
    );

    dma_word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(dev_valid), .push_data(dev_data),
        .pop(buf_pop), .head(buf_head), .empty(buf_empty), .full(buf_full)
    );

    dma_move_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .word_count(word_count), .buf_empty(buf_empty), .buf_head(buf_head),
        .bus_gnt(bus_gnt), .mem_wready(mem_wready), .busy(busy),
        .setup_ack(setup_ack), .bus_req(bus_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_pop(buf_pop), .done(done)
    );
endmodule

// File: rtl/dma_word_mover_chk.sv
module dma_word_mover_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [1:0]    cfg_sel,
    input logic          busy,
    input logic          setup_ack,
    input logic          irq,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_wready
);
    logic [AW-1:0] prev_addr;
    logic          seen;

    assert_ack_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ack |-> (busy && !bus_req));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_wready) |=> !bus_req);

    assert_we_granted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_req && bus_gnt));

    assert_idle_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we |-> (mem_addr == '0 && mem_wdata == '0));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !mem_we));

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cfg_wr && cfg_sel == 2'd3)) |=> irq);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !setup_ack && cfg_wr && cfg_sel == 2'd2) |=> !setup_ack);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr <= '0;
            seen      <= 1'b0;
        end else if (!busy) begin
            seen <= 1'b0;
        end else if (mem_we && mem_wready) begin
            if (seen) assert_addr_step_R6: assert (mem_addr == prev_addr + AW'(1));
            prev_addr <= mem_addr;
            seen      <= 1'b1;
        end
    end
endmodule

bind dma_word_mover dma_word_mover_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .busy(busy),
    .setup_ack(setup_ack), .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wready(mem_wready)
);

// File: tb/dma_word_mover_test.sv
`timescale 1ns/1ps
module dma_word_mover_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          busy, setup_ack, irq, dev_ready, bus_req, mem_we;
    logic          dev_valid = 1'b0;
    logic [DW-1:0] dev_data = '0;
    logic          bus_gnt = 1'b0;
    logic          mem_wready = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    always #2 clk = ~clk;

    dma_word_mover #(.AW(AW), .DW(DW), .DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .busy(busy), .setup_ack(setup_ack), .irq(irq),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wready(mem_wready)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int writes = 0;
    int req_seen = 0;
    logic [AW-1:0] last_wr_addr = '0;
    logic [DW-1:0] last_wr_data = '0;

    // behavioural model: phase 0 idle,1 ack,2 wait,3 request,4 write,5 finish
    logic [DW-1:0] mq[$];
    int            ph = 0;
    logic [AW-1:0] m_base = '0, m_cnt = '0, m_addr = '0, m_left = '0;
    logic          m_irq = 1'b0;
    bit            cmp_on = 1'b0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); ph = 0; m_irq = 1'b0; m_base = '0; m_cnt = '0;
        end else begin
            bit pop_now, push_now;
            int nph;
            pop_now  = (ph == 4) && mem_wready;
            push_now = dev_valid && (mq.size() < 16);
            if (ph == 5) m_irq = 1'b1;
            else if (cfg_wr && cfg_sel == 2'd3) m_irq = 1'b0;
            nph = ph;
            case (ph)
                0: if (cfg_wr && cfg_sel == 2'd2) begin
                       nph = 1; m_addr = m_base; m_left = m_cnt;
                   end
                1: nph = (m_left == 0) ? 5 : 2;
                2: if (mq.size() > 0) nph = 3;
                3: if (bus_gnt) nph = 4;
                4: if (mem_wready) begin
                       m_addr = m_addr + 1; m_left = m_left - 1;
                       nph = (m_left == 0) ? 5 : 2;
                   end
                default: nph = 0;
            endcase
            if (cfg_wr && ph == 0 && cfg_sel == 2'd0) m_base = cfg_wdata;
            if (cfg_wr && ph == 0 && cfg_sel == 2'd1) m_cnt  = cfg_wdata;
            ph = nph;
            if (pop_now)  void'(mq.pop_front());
            if (push_now) mq.push_back(dev_data);
        end
    end

    // compare, then drive arbiter and memory, then log writes
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk("R2/R7 busy", busy, ph != 0);
            chk("R2 setup_ack", setup_ack, ph == 1);
            chk("R3 dev_ready", dev_ready, mq.size() < 16);
            chk("R4 bus_req", bus_req, ph == 3 || ph == 4);
            chk("R5 mem_we", mem_we, ph == 4);
            if (ph == 4) begin
                chk("R6 mem_addr", mem_addr, m_addr);
                chk("R6 mem_wdata", mem_wdata, mq[0]);
            end else begin
                chk("R5 idle address", mem_addr, 0);
            end
            chk("R10 irq", irq, m_irq);
        end
        if (bus_req) req_seen++;
        bus_gnt    = bus_req && (bus_gnt || (cyc % 3 == 0));
        mem_wready = mem_we && (cyc % 2 == 0);
        if (mem_we && mem_wready) begin
            writes++;
            last_wr_addr = mem_addr;
            last_wr_data = mem_wdata;
        end
    end

    task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push_words(input int n, input logic [DW-1:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!dev_ready) @(negedge clk);
            dev_valid = 1'b1; dev_data = base + DW'(i);
            @(negedge clk);
            dev_valid = 1'b0;
            if (i % 3 == 1) @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        int k = 0;
        @(negedge clk);
        while (busy && k < 2000) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 irq", irq, 0);
        chk("R11 bus_req", bus_req, 0);
        chk("R11 mem_we", mem_we, 0);
        chk("R11 setup_ack", setup_ack, 0);
        chk("R11 dev_ready", dev_ready, 1);
        cmp_on = 1'b1;

        // R1 R6 R7 streaming transfer of 5 words
        cfg(2'd0, 32'h100);
        cfg(2'd1, 5);
        writes = 0;
        fork
            push_words(5, 32'hA0);
            cfg(2'd2, 0);
        join
        wait_idle();
        chk("R7 write count", writes, 5);
        chk("R1 R6 last address", last_wr_addr, 32'h104);
        chk("R6 last data", last_wr_data, 32'hA4);
        chk("R7 irq set", irq, 1);

        // R10 sticky, then cleared
        repeat (5) @(negedge clk);
        chk("R10 irq held", irq, 1);
        cfg(2'd3, 0);
        chk("R10 irq cleared", irq, 0);

        // R3 fill buffer with no transfer running
        push_words(16, 32'hB00);
        @(negedge clk);
        chk("R3 full ready low", dev_ready, 0);
        @(negedge clk);
        dev_valid = 1'b1; dev_data = 32'hDEAD;
        @(negedge clk);
        dev_valid = 1'b0;
        cfg(2'd0, 32'h200);
        cfg(2'd1, 20);
        writes = 0;
        fork
            cfg(2'd2, 0);
            push_words(4, 32'hB10);
        join
        wait_idle();
        chk("R3 R7 write count", writes, 20);
        chk("R6 last address", last_wr_addr, 32'h213);
        chk("R3 last data, overflow word dropped", last_wr_data, 32'hB13);
        cfg(2'd3, 0);

        // R9 R1 start and config writes while busy
        cfg(2'd0, 32'h300);
        cfg(2'd1, 3);
        writes = 0;
        cfg(2'd2, 0);
        cfg(2'd0, 32'hFFF);
        cfg(2'd1, 9);
        cfg(2'd2, 0);
        push_words(3, 32'hC0);
        wait_idle();
        chk("R9 write count", writes, 3);
        chk("R9 last address", last_wr_addr, 32'h302);
        chk("R7 irq", irq, 1);
        cfg(2'd3, 0);

        // R1: addresses loaded while busy were dropped; run 1 word
        cfg(2'd1, 1);
        writes = 0;
        fork
            cfg(2'd2, 0);
            push_words(1, 32'hE0);
        join
        wait_idle();
        chk("R1 base kept", last_wr_addr, 32'h300);
        cfg(2'd3, 0);

        // R8 zero count
        cfg(2'd1, 0);
        req_seen = 0;
        writes = 0;
        cfg(2'd2, 0);
        wait_idle();
        chk("R8 no bus request", req_seen, 0);
        chk("R8 no writes", writes, 0);
        chk("R8 irq", irq, 1);
        chk("R7 idle", busy, 0);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule